// File: doc/BRIEF.md
# Parallel-to-Serial Word Transmitter with Training Pattern

The block turns narrow parallel words into a continuous serial bit stream. It has two register stages. A capture stage takes one word per word slot. A shift stage takes that word on an internal strobe and moves it out one or two bits per enabled cycle. Both rates are modelled as enables on a single fast clock. A word slot lasts `WORD_W/LANES` enabled cycles. `LANES` is 1 for single-rate output and 2 when the `DDR` parameter is set. In DDR mode, lane 0 carries the rising-edge bit and lane 1 carries the falling-edge bit.

Words arrive on a valid/ready interface. `in_ready` is high only in the capture cycle of each slot. A word is taken when `in_valid` and `in_ready` are both high in that cycle. The source may hold `in_valid` high for as long as it likes, and a held word waits for the next slot. If a slot passes with no valid word, an all-zero word goes out. While `train` is high, the preset training word is captured in place of live data, and the source is not served. `en` freezes the whole block and forces the serial output low.

Top module: `word_serializer`

## Requirements
- R1: `rst` is synchronous and active high. It clears both stages and the slot counter. The serial output is low during reset and during the first SLOTS+1 enabled cycles after reset (SLOTS = WORD_W/LANES).
- R2: With `train` low, `in_ready` is high in exactly one enabled cycle per slot: the SLOTS-th enabled cycle counted from reset, then every SLOTS enabled cycles after that.
- R3: A word accepted in enabled cycle k is sent in enabled cycles k+2 through k+SLOTS+1. In SDR, bit 0 is sent first, then bits 1, 2 and 3 in that order. Words in consecutive slots follow each other with no gap.
- R4: A capture cycle with `in_valid` low captures an all-zero word, which is sent with the same timing as R3.
- R5: In a capture cycle with `train` high, `in_ready` is low and TRAIN_WORD (default 4'b1010) is captured and sent with R3 timing. Live data is not consumed in that cycle.
- R6: While `en` is low, `ser_out` is all zero and `in_ready` is low. The slot counter and both stages hold their values, and the stream resumes unchanged when `en` returns high.
- R7: With DDR=1, each enabled cycle carries two bits. Lane 0 carries the earlier bit. The first cycle of a word shows bits 1:0 and the second shows bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast bit clock |
| rst | input | 1 | synchronous reset, active high |
| en | input | 1 | block enable; low freezes state and silences the output |
| train | input | 1 | capture the preset training word instead of live data |
| in_valid | input | 1 | source has a word on `in_data` |
| in_ready | output | 1 | capture slot open for live data |
| in_data | input | WORD_W | parallel word; bit 0 is sent first |
| ser_out | output | LANES | serial output lanes |

## Verification
The assertions assume that `en`, `train`, `in_valid` and `in_data` change only between clock edges. They also assume that the parameters give at least two cycles per slot, so that the capture pulse and the load strobe never fall in the same cycle. The stimulus changes every input on the falling edge. It covers directed bursts of live data, a run with training held high, and a long random mix of enable gaps, idle slots and training slots. One stimulus stream feeds a single-rate instance and a double-rate instance.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // cycles needed to send one word
  function automatic int slots_of(input int word_w, input int lanes);
    return word_w / lanes;
  endfunction
  // counter width that holds 0..n-1, never zero
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ser_phase.sv
module ser_phase #(
  parameter int SLOTS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic capture,
  output logic strobe
);
  localparam int CW = ser_pkg::cnt_width(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic [CW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else if (en) ph <= (ph == LAST) ? '0 : ph + 1'b1;
  end

  assign capture = en && (ph == LAST);
  assign strobe  = en && (ph == '0);

  assert_single_event_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({capture, strobe}));
  assert_frozen_phase_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ph));
endmodule

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int WORD_W = 4,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              train,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic [WORD_W-1:0] cap_word
);
  logic [WORD_W-1:0] next_word;

  always_comb begin
    if (train)         next_word = TRAIN_WORD;
    else if (in_valid) next_word = in_data;
    else               next_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cap_word <= '0;
    else if (capture) cap_word <= next_word;
  end

  assign in_ready = capture && !train;

  assert_train_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (capture && train) |=> (cap_word == TRAIN_WORD));
  assert_idle_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (capture && !train && !in_valid) |=> (cap_word == '0));
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int WORD_W = 4,
  parameter int LANES  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              strobe,
  input  logic [WORD_W-1:0] cap_word,
  output logic [LANES-1:0]  lanes_out
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (strobe) shreg <= cap_word;
    else if (en) shreg <= shreg >> LANES;
  end

  generate
    if (LANES == 1) begin : g_sdr
      assign lanes_out = en ? shreg[0] : 1'b0;
    end else begin : g_ddr
      assign lanes_out = en ? shreg[LANES-1:0] : '0;
    end
  endgenerate

  assert_load_from_capture_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (shreg == $past(cap_word)));
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W = 4,
  parameter bit DDR    = 1'b0,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 4'b1010,
  localparam int LANES = DDR ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              train,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic [LANES-1:0]  ser_out
);
  localparam int SLOTS = ser_pkg::slots_of(WORD_W, LANES);

  logic capture, strobe;
  logic [WORD_W-1:0] cap_word;

  ser_phase #(.SLOTS(SLOTS)) phase_i (
    .clk(clk), .rst(rst), .en(en), .capture(capture), .strobe(strobe)
  );

  ser_capture #(.WORD_W(WORD_W), .TRAIN_WORD(TRAIN_WORD)) cap_i (
    .clk(clk), .rst(rst), .capture(capture), .train(train),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .cap_word(cap_word)
  );

  ser_shift #(.WORD_W(WORD_W), .LANES(LANES)) shift_i (
    .clk(clk), .rst(rst), .en(en), .strobe(strobe), .cap_word(cap_word),
    .lanes_out(ser_out)
  );

  assert_ready_rules_R2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (en && !train));
  assert_silent_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!en || $stable(cap_word)));
endmodule

// File: tb/word_serializer_tb_top.sv
module word_serializer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, train = 1'b0, in_valid = 1'b0;
  logic [3:0] in_data = '0;
  logic rdy_s, rdy_d;
  logic       out_s;
  logic [1:0] out_d;

  int checks = 0;
  int fails  = 0;
  int cnt_s = 0, cnt_d = 0;
  int q_s[$], q_d[$];
  string t_s[$], t_d[$];

  always #5 clk = ~clk;

  word_serializer #(.WORD_W(4), .DDR(1'b0)) dut_i (
    .clk(clk), .rst(rst), .en(en), .train(train), .in_valid(in_valid),
    .in_ready(rdy_s), .in_data(in_data), .ser_out(out_s)
  );
  word_serializer #(.WORD_W(4), .DDR(1'b1)) dut_ddr_i (
    .clk(clk), .rst(rst), .en(en), .train(train), .in_valid(in_valid),
    .in_ready(rdy_d), .in_data(in_data), .ser_out(out_d)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: push the expected lane values of a captured word
  task automatic push_word(input int m, input int word, input string tag);
    int lanes = (m == 0) ? 1 : 2;
    for (int j = 0; j < 4 / lanes; j++) begin
      int v = (word >> (j * lanes)) & ((1 << lanes) - 1);
      if (m == 0) begin q_s.push_back(v); t_s.push_back(tag); end
      else        begin q_d.push_back(v); t_d.push_back(tag); end
    end
  endtask

  // monitor side for one model, run once per cycle after inputs settle
  task automatic step(input int m);
    int slots = (m == 0) ? 4 : 2;
    int act   = (m == 0) ? int'(out_s) : int'(out_d);
    int rdy   = (m == 0) ? int'(rdy_s) : int'(rdy_d);
    int k     = (m == 0) ? cnt_s : cnt_d;
    int word;
    string tag;
    if (!en) begin
      check("R6 output low when disabled", act, 0);
      check("R6 ready low when disabled", rdy, 0);
      return;
    end
    if (m == 0) begin
      if (q_s.size() == 0) begin check("R3 queue underflow", 1, 0); end
      else begin tag = t_s.pop_front(); check(tag, act, q_s.pop_front()); end
    end else begin
      if (q_d.size() == 0) begin check("R7 queue underflow", 1, 0); end
      else begin tag = t_d.pop_front(); check(tag, act, q_d.pop_front()); end
    end
    check("R2 ready slot", rdy, ((k % slots) == slots - 1 && !train) ? 1 : 0);
    if ((k % slots) == slots - 1) begin
      if (train) begin word = 4'b1010; tag = "R5 training word"; end
      else if (in_valid) begin word = int'(in_data); tag = (m == 0) ? "R3 data order" : "R7 ddr lanes"; end
      else begin word = 0; tag = "R4 idle slot zero"; end
      push_word(m, word, tag);
    end
    if (m == 0) cnt_s++; else cnt_d++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset prefill, SLOTS+1 zero cycles
    for (int i = 0; i < 5; i++) begin q_s.push_back(0); t_s.push_back("R1 reset output"); end
    for (int i = 0; i < 3; i++) begin q_d.push_back(0); t_d.push_back("R1 reset output"); end
    en = 1'b1;
    in_valid = 1'b1;
    in_data = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", int'(rdy_s), 0);
    check("R1 output low in reset", int'(out_s), 0);
    check("R1 ddr output low in reset", int'(out_d), 0);
    rst = 1'b0;
    for (int c = 0; c < 2200; c++) begin
      if (c < 40) begin
        en = 1'b1; train = 1'b0; in_valid = 1'b1;
        in_data = 4'((c * 5 + 1) ^ (c >> 2));
      end else if (c < 64) begin
        en = 1'b1; train = 1'b1; in_valid = 1'b1; in_data = 4'h5;
      end else if (c < 80) begin
        en = 1'b1; train = 1'b0; in_valid = 1'b0;
      end else begin
        en = ($urandom % 6) != 0;
        train = ($urandom % 7) == 0;
        in_valid = ($urandom % 4) != 0;
        in_data = 4'($urandom);
      end
      #1;
      step(0);
      step(1);
      @(negedge clk);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule